// File: doc/BRIEF.md
# Memory-Intensity Phase Reconfiguration Controller

This controller sits between the shader array and a wide in-package memory interface. Every cycle it counts committed instructions and memory accesses. When the instruction count reaches a programmed interval length, it checks the interval's memory intensity, measured as accesses per thousand instructions, against a programmed threshold. Each interval is then classed as memory-bound or compute-bound. A one-bit predictor assumes the next interval behaves like the one just observed.

If the predicted class flips, the controller scans a table of eight candidate configurations, one entry per cycle. Each entry holds a bus width code, a frequency code, an estimated power and an estimated throughput.

- In a memory-bound phase, only entries at or above a programmed minimum frequency are eligible, and the one with the lowest power among them wins.
- In a compute-bound phase, the lowest-power entry wins, whatever its frequency.

The winner drives the lane enables and the voltage/frequency select. While the scan is running, the block reports itself busy.

Software loads the interval length, the threshold, the minimum frequency and the table through a simple write port.

Top module: `phase_reconfig_ctrl`

## Requirements
- R1: After reset, `bus_en_o` is 8'h0F (width code 2, 128 bits), `vf_sel_o` is 4, `phase_o` is 0 (compute-bound) and `busy_o` is 0. The reset interval length is 1,000,000, the threshold is 10, the minimum frequency is 4, and all table entries are zero.
- R2: The instruction counter counts cycles with `instr_i` high. An interval ends on the cycle whose instruction brings that count to the length register (address 0). Accesses (`mem_i` high) are counted on every cycle of the interval, including the last one. Both counters restart after each interval. Idle cycles never end an interval.
- R3: An interval is memory-bound (class 1) when accesses×1000 ≥ threshold×length. The threshold is the low 16 bits at address 1. A tie counts as memory-bound.
- R4: `phase_o` holds the class of the last evaluated interval. When a new class equals `phase_o`, the outputs do not change, no scan runs, and `busy_o` is high for exactly one cycle.
- R5: When the class changes, `phase_o` takes the new class and all 8 entries are scanned. `busy_o` is high for exactly 10 cycles after the interval's last edge. `bus_en_o` and `vf_sel_o` change only at the edge where `busy_o` falls.
- R6: In a memory-bound phase, only entries whose frequency code is at least the minimum frequency (address 2, low 3 bits) are eligible. The eligible entry with the lowest power wins. Equal power goes to the higher throughput, and after that to the lower index.
- R7: In a compute-bound phase, all entries are eligible, and the winner is chosen by the same ordering as in R6.
- R8: If no entry is eligible, `bus_en_o` and `vf_sel_o` keep their values, but `phase_o` still takes the new class.
- R9: An interval that ends while `busy_o` is high is not evaluated: it leaves `phase_o` and the outputs untouched. Its counts are discarded.
- R10: A width code w drives the low 2^w bits of `bus_en_o` high and the rest low, with each lane 32 bits wide. `vf_sel_o` equals the frequency code of the selected entry.
- R11: A write with `cfg_we_i` at addresses 8 to 15 loads table entry (address−8). The data fields are: width [1:0], frequency [6:4], throughput [15:8] and power [27:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 1 | One instruction committed this cycle |
| mem_i | input | 1 | One memory access this cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| bus_en_o | output | 8 | Data lane enables, thermometer coded |
| vf_sel_o | output | 3 | Memory voltage/frequency point select |
| phase_o | output | 1 | Predicted class, 1 = memory-bound |
| busy_o | output | 1 | Evaluation or reconfiguration in progress |

## Verification
The assertions check on every cycle that:
- the lane enables stay a thermometer code;
- the outputs move only on the apply step, and the predicted class moves only on the classify step;
- an interval that ends while busy never starts an evaluation;
- a memory-bound winner meets the minimum frequency.

The bench scenarios cover what those checks cannot see:
- the exact interval boundary and the tie at the threshold;
- the ten-cycle busy window;
- the order in which power, throughput and index break ties, with a directed and a random table;
- the case with no eligible entry;
- a short interval that expires during a scan and is dropped.

// File: rtl/phase_pkg.sv
package phase_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CLASS, ST_SCAN, ST_APPLY} ctrl_st_e;
  localparam int F_WID_LSB = 0;
  localparam int F_FRQ_LSB = 4;
  localparam int F_TP_LSB  = 8;
  localparam int F_PW_LSB  = 16;
endpackage

// File: rtl/phase_sampler.sv
module phase_sampler #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_i,
  input  logic             mem_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             end_o,
  output logic [CNT_W-1:0] mem_tot_o
);
  logic [CNT_W-1:0] icnt_q, mcnt_q;
  logic [CNT_W:0]   icnt_nx;

  assign icnt_nx   = {1'b0, icnt_q} + (CNT_W+1)'(1);
  assign end_o     = instr_i && (icnt_nx >= {1'b0, len_i});
  assign mem_tot_o = mcnt_q + CNT_W'(mem_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt_q <= '0;
      mcnt_q <= '0;
    end else if (end_o) begin
      icnt_q <= '0;
      mcnt_q <= '0;
    end else begin
      icnt_q <= icnt_q + CNT_W'(instr_i);
      mcnt_q <= mem_tot_o;
    end
  end
endmodule

// File: rtl/phase_cfg_regs.sv
module phase_cfg_regs
  import phase_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int THR_W   = 16,
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int N_CFG   = 8,
  parameter int WID_W   = 2,
  parameter int FREQ_W  = 3,
  parameter int TP_W    = 8,
  parameter int PW_W    = 12,
  parameter logic [CNT_W-1:0]  RST_LEN = CNT_W'(1_000_000),
  parameter logic [THR_W-1:0]  RST_THR = THR_W'(10),
  parameter logic [FREQ_W-1:0] RST_HI  = FREQ_W'(4)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [AW-1:0]                     addr_i,
  input  logic [DW-1:0]                     wdata_i,
  output logic [CNT_W-1:0]                  len_o,
  output logic [THR_W-1:0]                  thr_o,
  output logic [FREQ_W-1:0]                 hi_o,
  output logic [N_CFG-1:0][WID_W-1:0]       wid_o,
  output logic [N_CFG-1:0][FREQ_W-1:0]      frq_o,
  output logic [N_CFG-1:0][TP_W-1:0]        tp_o,
  output logic [N_CFG-1:0][PW_W-1:0]        pw_o
);
  localparam int IDX_W = $clog2(N_CFG);
  logic unused_bits;
  assign unused_bits = ^wdata_i[DW-1:F_PW_LSB+PW_W] ^ ^wdata_i[F_FRQ_LSB-1:F_WID_LSB+WID_W]
                     ^ wdata_i[F_TP_LSB-1] ^ ^addr_i[AW-2:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o <= RST_LEN;
      thr_o <= RST_THR;
      hi_o  <= RST_HI;
    end else if (we_i && !addr_i[AW-1]) begin
      if (addr_i == AW'(0)) len_o <= wdata_i[CNT_W-1:0];
      if (addr_i == AW'(1)) thr_o <= wdata_i[THR_W-1:0];
      if (addr_i == AW'(2)) hi_o  <= wdata_i[FREQ_W-1:0];
    end
  end

  for (genvar k = 0; k < N_CFG; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wid_o[k] <= '0;
        frq_o[k] <= '0;
        tp_o[k]  <= '0;
        pw_o[k]  <= '0;
      end else if (we_i && addr_i[AW-1] && (addr_i[IDX_W-1:0] == IDX_W'(k))) begin
        wid_o[k] <= wdata_i[F_WID_LSB +: WID_W];
        frq_o[k] <= wdata_i[F_FRQ_LSB +: FREQ_W];
        tp_o[k]  <= wdata_i[F_TP_LSB +: TP_W];
        pw_o[k]  <= wdata_i[F_PW_LSB +: PW_W];
      end
    end
  end
endmodule

// File: rtl/phase_scanner.sv
module phase_scanner #(
  parameter int WID_W  = 2,
  parameter int FREQ_W = 3,
  parameter int TP_W   = 8,
  parameter int PW_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic              mem_bound_i,
  input  logic [FREQ_W-1:0] hi_i,
  input  logic [WID_W-1:0]  wid_i,
  input  logic [FREQ_W-1:0] frq_i,
  input  logic [TP_W-1:0]   tp_i,
  input  logic [PW_W-1:0]   pw_i,
  output logic              vld_o,
  output logic [WID_W-1:0]  wid_o,
  output logic [FREQ_W-1:0] frq_o
);
  logic [TP_W-1:0] best_tp_q;
  logic [PW_W-1:0] best_pw_q;
  logic elig, better;

  assign elig   = !mem_bound_i || (frq_i >= hi_i);
  // power first, then throughput; earlier index kept on full tie
  assign better = !vld_o || (pw_i < best_pw_q) || ((pw_i == best_pw_q) && (tp_i > best_tp_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o     <= 1'b0;
      wid_o     <= '0;
      frq_o     <= '0;
      best_tp_q <= '0;
      best_pw_q <= '0;
    end else if (start_i) begin
      vld_o <= 1'b0;
    end else if (step_i && elig && better) begin
      vld_o     <= 1'b1;
      wid_o     <= wid_i;
      frq_o     <= frq_i;
      best_tp_q <= tp_i;
      best_pw_q <= pw_i;
    end
  end
endmodule

// File: rtl/phase_reconfig_ctrl.sv
module phase_reconfig_ctrl
  import phase_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int THR_W  = 16,
  parameter int AW     = 4,
  parameter int DW     = 32,
  parameter int N_CFG  = 8,
  parameter int WID_W  = 2,
  parameter int FREQ_W = 3,
  parameter int TP_W   = 8,
  parameter int PW_W   = 12,
  parameter logic [WID_W-1:0]  RST_WID  = WID_W'(2),
  parameter logic [FREQ_W-1:0] RST_FREQ = FREQ_W'(4),
  localparam int LANES = 1 << ((1 << WID_W) - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_i,
  input  logic              mem_i,
  input  logic              cfg_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic [LANES-1:0]  bus_en_o,
  output logic [FREQ_W-1:0] vf_sel_o,
  output logic              phase_o,
  output logic              busy_o
);
  localparam int IDX_W  = $clog2(N_CFG);
  localparam int PROD_W = CNT_W + THR_W;

  logic [CNT_W-1:0]  len, s_mem, mfin_q;
  logic [THR_W-1:0]  thr;
  logic [FREQ_W-1:0] hi;
  logic [N_CFG-1:0][WID_W-1:0]  t_wid;
  logic [N_CFG-1:0][FREQ_W-1:0] t_frq;
  logic [N_CFG-1:0][TP_W-1:0]   t_tp;
  logic [N_CFG-1:0][PW_W-1:0]   t_pw;
  logic              s_end, cls, best_vld;
  logic [WID_W-1:0]  best_wid, wid_q;
  logic [FREQ_W-1:0] best_frq, frq_q;
  logic [IDX_W-1:0]  idx_q;
  ctrl_st_e          st_q;

  phase_sampler #(.CNT_W(CNT_W)) u_smp (
    .clk_i, .rst_ni, .instr_i, .mem_i, .len_i(len), .end_o(s_end), .mem_tot_o(s_mem)
  );

  phase_cfg_regs #(
    .CNT_W(CNT_W), .THR_W(THR_W), .AW(AW), .DW(DW), .N_CFG(N_CFG),
    .WID_W(WID_W), .FREQ_W(FREQ_W), .TP_W(TP_W), .PW_W(PW_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .len_o(len), .thr_o(thr), .hi_o(hi),
    .wid_o(t_wid), .frq_o(t_frq), .tp_o(t_tp), .pw_o(t_pw)
  );

  phase_scanner #(.WID_W(WID_W), .FREQ_W(FREQ_W), .TP_W(TP_W), .PW_W(PW_W)) u_scan (
    .clk_i, .rst_ni,
    .start_i(st_q == ST_CLASS), .step_i(st_q == ST_SCAN), .mem_bound_i(phase_o), .hi_i(hi),
    .wid_i(t_wid[idx_q]), .frq_i(t_frq[idx_q]), .tp_i(t_tp[idx_q]), .pw_i(t_pw[idx_q]),
    .vld_o(best_vld), .wid_o(best_wid), .frq_o(best_frq)
  );

  // intensity >= threshold, without division
  assign cls = (PROD_W'(mfin_q) * PROD_W'(1000)) >= (PROD_W'(thr) * PROD_W'(len));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mfin_q  <= '0;
      idx_q   <= '0;
      phase_o <= 1'b0;
      wid_q   <= RST_WID;
      frq_q   <= RST_FREQ;
    end else begin
      unique case (st_q)
        ST_IDLE: if (s_end) begin
          mfin_q <= s_mem;
          st_q   <= ST_CLASS;
        end
        ST_CLASS: if (cls != phase_o) begin
          phase_o <= cls;
          idx_q   <= '0;
          st_q    <= ST_SCAN;
        end else begin
          st_q <= ST_IDLE;
        end
        ST_SCAN: begin
          idx_q <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(N_CFG-1)) st_q <= ST_APPLY;
        end
        ST_APPLY: begin
          if (best_vld) begin
            wid_q <= best_wid;
            frq_q <= best_frq;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign vf_sel_o = frq_q;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_en_o[g] = (32'(g) < (32'd1 << wid_q));
  end

  // R9
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_end && st_q != ST_IDLE) |=> (st_q != ST_CLASS));
  // R5
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_APPLY) |=> ($stable(vf_sel_o) && $stable(bus_en_o)));
  // R4
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_CLASS) |=> $stable(phase_o));
  // R10
  lane_therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_en_o[0] && ((bus_en_o & (bus_en_o + LANES'(1))) == '0));
  // R6
  hi_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_APPLY && best_vld && phase_o) |-> (best_frq >= hi));
endmodule

// File: tb/phase_reconfig_ctrl_test.sv
module phase_reconfig_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic instr_i = 1'b0, mem_i = 1'b0, cfg_we_i = 1'b0;
  logic [3:0] cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [7:0] bus_en_o;
  logic [2:0] vf_sel_o;
  logic phase_o, busy_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int tw[8], tf[8], tt[8], tp[8];
  int ph, ew, ef, len, thr, hi;

  phase_reconfig_ctrl uut (
    .clk_i(clk), .rst_ni, .instr_i, .mem_i, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .bus_en_o, .vf_sel_o, .phase_o, .busy_o
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(a); cfg_wdata_i = 32'(d);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_ent(int k, int w, int f, int t, int p);
    tw[k] = w; tf[k] = f; tt[k] = t; tp[k] = p;
    // R11 field layout
    wr(8 + k, {4'h0, 12'(p), 8'(t), 1'b0, 3'(f), 2'b00, 2'(w)});
  endtask

  function automatic int pick(int mb);
    int b = -1;
    for (int k = 0; k < 8; k++) begin
      if (mb == 0 || tf[k] >= hi) begin
        if (b < 0 || tp[k] < tp[b] || (tp[k] == tp[b] && tt[k] > tt[b])) b = k;
      end
    end
    return b;
  endfunction

  function automatic int lanes(int w);
    return (1 << (1 << w)) - 1;
  endfunction

  task automatic run_iv(int m, bit gap, string tag);
    int lat, cls, k, elat;
    for (int i = 0; i < len; i++) begin
      if (gap && i == len - 1) begin
        instr_i = 1'b0; mem_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 no end before last instruction", int'(busy_o), 0);
      end
      instr_i = 1'b1; mem_i = (i < m);
      @(negedge clk);
    end
    instr_i = 1'b0; mem_i = 1'b0;
    lat = 0;
    while (busy_o) begin @(negedge clk); lat++; end
    cls = (longint'(m) * 1000 >= longint'(thr) * len) ? 1 : 0;
    elat = 1;
    if (cls != ph) begin
      ph = cls; elat = 10;
      k = pick(cls);
      if (k >= 0) begin ew = tw[k]; ef = tf[k]; end
    end
    chk({tag, " busy length R4/R5"}, lat, elat);
    chk({tag, " phase R3"}, int'(phase_o), ph);
    chk({tag, " lanes R6/R7/R10"}, int'(bus_en_o), lanes(ew));
    chk({tag, " vf R6/R7/R10"}, int'(vf_sel_o), ef);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    ph = 0; ew = 2; ef = 4; len = 1000000; thr = 10; hi = 4;
    for (int k = 0; k < 8; k++) begin tw[k] = 0; tf[k] = 0; tt[k] = 0; tp[k] = 0; end
    repeat (3) @(negedge clk);
    // R1
    chk("R1 lanes", int'(bus_en_o), 8'h0F);
    chk("R1 vf", int'(vf_sel_o), 4);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 lanes after release", int'(bus_en_o), 8'h0F);

    len = 100; thr = 30; hi = 4;
    wr(0, len); wr(1, thr); wr(2, hi);
    set_ent(0, 0, 1, 2, 30); set_ent(1, 1, 2, 1, 25);
    set_ent(2, 2, 4, 5, 40); set_ent(3, 3, 5, 3, 60);
    set_ent(4, 1, 5, 4, 45); set_ent(5, 0, 0, 3, 10);
    set_ent(6, 3, 6, 9, 40); set_ent(7, 2, 3, 3, 10);

    run_iv(2, 0, "R4 compute no change");
    run_iv(3, 1, "R2 R3 tie memory-bound R6");
    run_iv(4, 0, "R4 memory stays");
    run_iv(0, 0, "R7 compute tie order");
    hi = 7; wr(2, hi);
    run_iv(5, 0, "R8 no eligible");
    hi = 4; wr(2, hi);
    run_iv(0, 0, "R7 back to compute");

    // R9: second short interval ends during the scan and is dropped
    len = 4; wr(0, len);
    for (int i = 0; i < 8; i++) begin
      instr_i = 1'b1; mem_i = (i == 0);
      @(negedge clk);
    end
    instr_i = 1'b0; mem_i = 1'b0;
    while (busy_o) @(negedge clk);
    ph = 1; ew = tw[pick(1)]; ef = tf[pick(1)];
    chk("R9 dropped interval phase", int'(phase_o), 1);
    chk("R9 lanes", int'(bus_en_o), lanes(ew));
    chk("R9 vf", int'(vf_sel_o), ef);
    repeat (3) @(negedge clk);
    chk("R9 no late evaluation", int'(busy_o), 0);
    len = 100; wr(0, len);

    for (int r = 0; r < 30; r++) begin
      if (r % 6 == 0) begin
        for (int k = 0; k < 8; k++)
          set_ent(k, $urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 15));
        hi = $urandom_range(0, 7); wr(2, hi);
      end
      run_iv($urandom_range(0, 6), 0, "random R3 R6 R7");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule